// File: doc/BRIEF.md
# Board Control Register with Parity Capture

This block holds the 16-bit control and status word of a network interface board, together with two registers that report RAM parity errors. The host reaches it over a plain word-wide register bus: a write strobe with a word address and data, and a read data bus that follows the address in the same cycle. The stored control bits drive the network controller's reset, its channel-attention input, the loopback/on-air select, the expansion-bus enable and the RAM part-size select. The block also merges the controller's interrupt and the parity condition into a single interrupt request.

The RAM parity checker itself lies outside the block. It appears here as a one-cycle error strobe that comes with the 20-bit failing address, a source bit and a byte-lane bit. The first error is held in the block, with its address split into a 4-bit high part and a 16-bit low part, until the host acknowledges it by a write. The host pulses attention with a read-modify-write that sets the attention bit and a second one that clears it. It enters run mode with a read-modify-write that sets on-air and both interrupt enables.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset every output is 0, and the status word reads as its strap bits only (bits 3:0 equal `ram_base_i`, all other bits 0).
- R2: A host write to the status word (word offset 1056) stores bits 15, 14, 12, 11, 5 and 4. From the next cycle bit 15 drives `ctl_reset_o`, bit 14 drives `onair_o`, bit 5 drives `xbus_en_o` and bit 4 drives `ram256_o`, and the stored bits read back.
- R3: `ctl_attn_o` follows status bit 13 from the cycle after the write. A write that sets it followed at once by a write that clears it gives a one-cycle pulse.
- R4: A read-modify-write that ORs 0x5800 into the status word (run mode: bits 14, 12, 11) sets those bits and leaves every other stored bit unchanged.
- R5: Status bits 9, 8 and 3:0 are read-only, and host writes to them have no effect. Bit 8 shows `ctl_irq_i` delayed by one clock. Bits 3:0 show `ram_base_i`.
- R6: A `par_err_i` strobe while no error is held sets status bit 9 from the next cycle. Parity control (offset 1058) then reads bit 7 = source, bit 6 = byte lane, bits 3:0 = address bits 19:16. Parity address (offset 1059) reads address bits 15:0.
- R7: While status bit 9 is set, further strobes are ignored and the captured fields stay unchanged.
- R8: A write to offset 1058 with bit 8 set clears status bit 9 from the next cycle, and a write with bit 8 clear has no effect. Bit 8 always reads 0. A strobe in the same cycle as an acknowledge is captured as a new error.
- R9: `irq_o` = (status bit 8 AND bit 12) OR (status bit 9 AND bit 11).
- R10: Offsets other than 1056, 1058 and 1059 read 0, including the filler word at 1057, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 11 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` |
| ram_base_i | input | 4 | Strap: RAM base address bits 17-20 |
| ctl_irq_i | input | 1 | Controller interrupt level |
| par_err_i | input | 1 | Parity error strobe |
| par_addr_i | input | 20 | Failing RAM address |
| par_src_i | input | 1 | Error source |
| par_lane_i | input | 1 | Failing byte lane |
| ctl_reset_o | output | 1 | Controller reset |
| ctl_attn_o | output | 1 | Channel attention |
| onair_o | output | 1 | Out of loopback when 1 |
| xbus_en_o | output | 1 | Expansion bus enable |
| ram256_o | output | 1 | 256K RAM part select |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acknowledge write in the same clock as a new parity strobe, where the clear and the capture collide. The bench drives the write and the strobe in the same cycle, with an address that differs from the one already held. It then reads all three registers to show that the new error replaced the old one and that the flag stayed set. A strobe while an error is held is also driven with different fields, to show that the capture does not change.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int WORD_W = 16;
  // status word bit positions (decoded by host software)
  localparam int B_RESET = 15;
  localparam int B_ONAIR = 14;
  localparam int B_ATTN  = 13;
  localparam int B_IEN   = 12;
  localparam int B_PIEN  = 11;
  localparam int B_PFLAG = 9;
  localparam int B_IFLAG = 8;
  localparam int B_XBUS  = 5;
  localparam int B_R256  = 4;
  // parity control bit positions
  localparam int P_ACK  = 8;
  localparam int P_SRC  = 7;
  localparam int P_LANE = 6;
  localparam logic [WORD_W-1:0] WR_MASK = 16'hF830;

  typedef struct packed {
    logic src;
    logic lane;
  } perr_info_t;
endpackage

// File: rtl/bcr_status.sv
module bcr_status
  import bcr_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              ctl_irq_i,
  input  logic [HI_W-1:0]   ram_base,
  input  logic              pe_flag,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] ctrl_q;
  logic              iflag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      iflag_q <= 1'b0;
    end else begin
      iflag_q <= ctl_irq_i;
      if (wr_en) ctrl_q <= wdata & WR_MASK;
    end
  end

  always_comb begin
    word          = ctrl_q;
    word[B_PFLAG] = pe_flag;
    word[B_IFLAG] = iflag_q;
    word[HI_W-1:0] = ram_base;
  end
endmodule

// File: rtl/bcr_parity.sv
module bcr_parity
  import bcr_pkg::*;
#(
  parameter int HI_W = 4,
  parameter int LO_W = 16,
  localparam int A_W = HI_W + LO_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ack,
  input  logic           err,
  input  logic [A_W-1:0] err_addr,
  input  perr_info_t     err_info,
  output logic           flag,
  output logic [A_W-1:0] addr_q,
  output perr_info_t     info_q
);
  logic take;
  // a strobe is taken when nothing is held, or when the hold is being released
  assign take = err && (!flag || ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      addr_q <= '0;
      info_q <= '0;
    end else begin
      if (take) begin
        flag   <= 1'b1;
        addr_q <= err_addr;
        info_q <= err_info;
      end else if (ack) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import bcr_pkg::*;
#(
  parameter int MAP_WORDS = 1024,
  parameter int ID_WORDS  = 32,
  parameter int ADDR_W    = 11,
  parameter int HI_W      = 4,
  parameter int LO_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [15:0]          host_wdata,
  output logic [15:0]          host_rdata,
  input  logic [HI_W-1:0]      ram_base_i,
  input  logic                 ctl_irq_i,
  input  logic                 par_err_i,
  input  logic [HI_W+LO_W-1:0] par_addr_i,
  input  logic                 par_src_i,
  input  logic                 par_lane_i,
  output logic                 ctl_reset_o,
  output logic                 ctl_attn_o,
  output logic                 onair_o,
  output logic                 xbus_en_o,
  output logic                 ram256_o,
  output logic                 irq_o
);
  localparam int STAT_IDX  = MAP_WORDS + ID_WORDS;
  localparam int PCTL_IDX  = STAT_IDX + 2;
  localparam int PADDR_IDX = STAT_IDX + 3;
  localparam int A_W       = HI_W + LO_W;

  logic              sel_stat, sel_pctl, sel_paddr;
  logic              ack_wr;
  logic [WORD_W-1:0] stat_word;
  logic              pe_flag;
  logic [A_W-1:0]    pe_addr;
  perr_info_t        pe_info, in_info;

  assign sel_stat  = (host_addr == ADDR_W'(STAT_IDX));
  assign sel_pctl  = (host_addr == ADDR_W'(PCTL_IDX));
  assign sel_paddr = (host_addr == ADDR_W'(PADDR_IDX));
  assign ack_wr    = host_wr && sel_pctl && host_wdata[P_ACK];
  assign in_info   = '{src: par_src_i, lane: par_lane_i};

  bcr_status #(.HI_W(HI_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr && sel_stat), .wdata(host_wdata),
    .ctl_irq_i(ctl_irq_i), .ram_base(ram_base_i),
    .pe_flag(pe_flag), .word(stat_word)
  );

  bcr_parity #(.HI_W(HI_W), .LO_W(LO_W)) u_parity (
    .clk(clk), .rst_n(rst_n), .ack(ack_wr),
    .err(par_err_i), .err_addr(par_addr_i), .err_info(in_info),
    .flag(pe_flag), .addr_q(pe_addr), .info_q(pe_info)
  );

  always_comb begin
    host_rdata = '0;
    if (sel_stat) begin
      host_rdata = stat_word;
    end else if (sel_pctl) begin
      host_rdata[P_SRC]    = pe_info.src;
      host_rdata[P_LANE]   = pe_info.lane;
      host_rdata[HI_W-1:0] = pe_addr[A_W-1:LO_W];
    end else if (sel_paddr) begin
      host_rdata[LO_W-1:0] = pe_addr[LO_W-1:0];
    end
  end

  assign ctl_reset_o = stat_word[B_RESET];
  assign ctl_attn_o  = stat_word[B_ATTN];
  assign onair_o     = stat_word[B_ONAIR];
  assign xbus_en_o   = stat_word[B_XBUS];
  assign ram256_o    = stat_word[B_R256];
  assign irq_o = (stat_word[B_IFLAG] && stat_word[B_IEN]) ||
                 (stat_word[B_PFLAG] && stat_word[B_PIEN]);
endmodule

// File: rtl/board_ctl_chk.sv
module board_ctl_chk #(
  parameter int ADDR_W = 11,
  parameter int A_W    = 20,
  parameter int STAT_IDX = 1056,
  parameter int PCTL_IDX = 1058
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [15:0]       host_wdata,
  input logic              par_err_i,
  input logic [A_W-1:0]    par_addr_i,
  input logic              ctl_attn_o,
  input logic              irq_o,
  input logic [15:0]       stat_word,
  input logic              pe_flag,
  input logic [A_W-1:0]    pe_addr
);
  logic stat_wr, ack_w;
  assign stat_wr = host_wr && (host_addr == ADDR_W'(STAT_IDX));
  assign ack_w   = host_wr && (host_addr == ADDR_W'(PCTL_IDX)) && host_wdata[8];

  assert_attn_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (ctl_attn_o == $past(host_wdata[13])));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_i && !pe_flag) |=> (pe_flag && pe_addr == $past(par_addr_i)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_flag && !ack_w) |=> (pe_flag && $stable(pe_addr)));

  assert_ack_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && !par_err_i) |=> !pe_flag);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_word[12] && !stat_word[11]) |-> !irq_o);
endmodule

bind board_ctl_regs board_ctl_chk #(
  .ADDR_W(ADDR_W), .A_W(A_W), .STAT_IDX(STAT_IDX), .PCTL_IDX(PCTL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .par_err_i(par_err_i), .par_addr_i(par_addr_i),
  .ctl_attn_o(ctl_attn_o), .irq_o(irq_o), .stat_word(stat_word),
  .pe_flag(pe_flag), .pe_addr(pe_addr)
);

// File: tb/tb_board_ctl_regs.sv
module tb_board_ctl_regs;
  localparam logic [10:0] A_STAT = 11'd1056, A_FILL = 11'd1057,
                          A_PCTL = 11'd1058, A_PADDR = 11'd1059;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [10:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic [3:0] ram_base_i = 4'hA;
  logic ctl_irq_i = 1'b0, par_err_i = 1'b0, par_src_i = 1'b0, par_lane_i = 1'b0;
  logic [19:0] par_addr_i = '0;
  logic ctl_reset_o, ctl_attn_o, onair_o, xbus_en_o, ram256_o, irq_o;
  int n_chk = 0, n_fail = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  board_ctl_regs dut (.*);

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic strobe(input logic [19:0] a, input logic s, input logic l);
    @(negedge clk);
    par_err_i = 1'b1; par_addr_i = a; par_src_i = s; par_lane_i = l;
    @(negedge clk);
    par_err_i = 1'b0;
  endtask

  task automatic t_reset();
    rd(A_STAT, rv);
    check(rv == 16'h000A, "R1 status after reset", rv, 16'h000A);
    check({ctl_reset_o, ctl_attn_o, onair_o, xbus_en_o, ram256_o, irq_o} == 6'b0,
          "R1 outputs after reset", {ctl_reset_o, ctl_attn_o, onair_o, xbus_en_o, ram256_o, irq_o}, 0);
  endtask

  task automatic t_write_bits();
    wr(A_STAT, 16'h8000);
    check(ctl_reset_o == 1'b1, "R2 reset output set", ctl_reset_o, 1);
    wr(A_STAT, 16'h0000);
    check(ctl_reset_o == 1'b0, "R2 reset output cleared", ctl_reset_o, 0);
    wr(A_STAT, 16'h4030);
    check({onair_o, xbus_en_o, ram256_o} == 3'b111, "R2 onair/xbus/256", {onair_o, xbus_en_o, ram256_o}, 3'b111);
    rd(A_STAT, rv);
    check(rv == 16'h403A, "R2 readback", rv, 16'h403A);
    // R5: writes to read-only bits ignored
    wr(A_STAT, 16'h034F);
    rd(A_STAT, rv);
    check(rv == 16'h000A, "R5 read-only bits ignore write", rv, 16'h000A);
    ram_base_i = 4'h3;
    rd(A_STAT, rv);
    check(rv[3:0] == 4'h3, "R5 strap bits follow input", rv[3:0], 3);
    ram_base_i = 4'hA;
  endtask

  task automatic t_attention();
    wr(A_STAT, 16'h2000);
    check(ctl_attn_o == 1'b1, "R3 attention high", ctl_attn_o, 1);
    wr(A_STAT, 16'h0000);
    check(ctl_attn_o == 1'b0, "R3 attention one-cycle pulse", ctl_attn_o, 0);
  endtask

  task automatic t_run_mode();
    wr(A_STAT, 16'h0020);
    rd(A_STAT, rv);
    wr(A_STAT, rv | 16'h5800);
    rd(A_STAT, rv);
    check(rv == 16'h582A, "R4 run mode keeps other bits", rv, 16'h582A);
    check(onair_o && xbus_en_o, "R4 onair and xbus", {onair_o, xbus_en_o}, 2'b11);
  endtask

  task automatic t_irq();
    // run mode leaves IEN and PIEN set
    check(irq_o == 1'b0, "R9 no source no irq", irq_o, 0);
    @(negedge clk); ctl_irq_i = 1'b1;
    @(negedge clk);
    rd(A_STAT, rv);
    check(rv[8] == 1'b1, "R5 interrupt flag follows input", rv[8], 1);
    check(irq_o == 1'b1, "R9 irq from controller", irq_o, 1);
    wr(A_STAT, 16'h4000);
    check(irq_o == 1'b0, "R9 irq masked by IEN", irq_o, 0);
    ctl_irq_i = 1'b0;
  endtask

  task automatic t_parity();
    wr(A_STAT, 16'h0800);
    strobe(20'h5_1234, 1'b1, 1'b0);
    rd(A_STAT, rv);
    check(rv[9] == 1'b1, "R6 parity flag set", rv[9], 1);
    check(irq_o == 1'b1, "R9 irq from parity", irq_o, 1);
    rd(A_PCTL, rv);
    check(rv == 16'h0085, "R6 parity control fields", rv, 16'h0085);
    rd(A_PADDR, rv);
    check(rv == 16'h1234, "R6 parity low address", rv, 16'h1234);
    strobe(20'hC_BEEF, 1'b0, 1'b1);
    rd(A_PCTL, rv);
    check(rv == 16'h0085, "R7 second error ignored (ctl)", rv, 16'h0085);
    rd(A_PADDR, rv);
    check(rv == 16'h1234, "R7 second error ignored (addr)", rv, 16'h1234);
    wr(A_PCTL, 16'h00FF);
    rd(A_STAT, rv);
    check(rv[9] == 1'b1, "R8 write without ack bit no effect", rv[9], 1);
    wr(A_PCTL, 16'h0100);
    rd(A_STAT, rv);
    check(rv[9] == 1'b0, "R8 ack clears flag", rv[9], 0);
    rd(A_PCTL, rv);
    check(rv[8] == 1'b0, "R8 ack bit reads 0", rv[8], 0);
  endtask

  task automatic t_ack_collide();
    strobe(20'h1_0001, 1'b0, 1'b0);
    @(negedge clk);
    host_wr = 1'b1; host_addr = A_PCTL; host_wdata = 16'h0100;
    par_err_i = 1'b1; par_addr_i = 20'h7_ABCD; par_src_i = 1'b0; par_lane_i = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; par_err_i = 1'b0;
    rd(A_STAT, rv);
    check(rv[9] == 1'b1, "R8 collision keeps flag", rv[9], 1);
    rd(A_PCTL, rv);
    check(rv == 16'h0047, "R8 collision captures new ctl", rv, 16'h0047);
    rd(A_PADDR, rv);
    check(rv == 16'hABCD, "R8 collision captures new addr", rv, 16'hABCD);
  endtask

  task automatic t_other_offsets();
    wr(A_FILL, 16'hFFFF);
    rd(A_FILL, rv);
    check(rv == 16'h0, "R10 filler reads 0", rv, 0);
    wr(11'd5, 16'hFFFF);
    rd(11'd5, rv);
    check(rv == 16'h0, "R10 other offset reads 0", rv, 0);
    rd(A_STAT, rv);
    check(rv == 16'h0A0A, "R10 status untouched", rv, 16'h0A0A);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_bits();
        t_attention();
        t_run_mode();
        t_irq();
        t_parity();
        t_ack_collide();
        t_other_offsets();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule